// File: doc/BRIEF.md
# SHA-256 Block Compression Engine

This block is a register-mapped SHA-256 compression engine. Software places one 512-bit message block in sixteen 32-bit word registers and then writes a command word to a control register. The engine compresses the block into a 256-bit chaining state, which software reads back as eight words. Message padding and the length field are prepared by software before the block is loaded.

There are two start commands. The first-block command seeds the chaining state with the standard SHA-256 initial hash before compressing. The continuation command compresses from whatever chaining state the previous block left. A separate two-write sequence clears the engine back to a zero state. While a block is being compressed, bit 0 of the control register reads as 1. The engine performs one round per clock.

The bus is word-addressed. Word index 0 is the control register. Indices 4..19 hold the block (byte offsets 0x10..0x4F). Indices 24..31 hold the state (byte offsets 0x60..0x7F). Reads are combinational, and writes take effect at the clock edge where `bus_wr` is high.

Top module: `sha256_cmd_engine`

## Requirements
- R1: After reset, the control register reads 0, every state word reads 0 and every block word reads 0.
- R2: Block word i (0..15) is written and read at word index 4+i and is message word W[i], most significant byte first. Compression leaves the block registers unchanged.
- R3: Writing 0x0000000A to the control register while idle loads the standard SHA-256 initial hash into the state and compresses the block from it. This happens even when the state already holds an earlier digest.
- R4: Writing 0x0000000E to the control register while idle compresses the block starting from the current state, so that consecutive blocks chain into one multi-block digest.
- R5: Control read bit 0 is the busy flag, and all other bits read 0. After a start command, busy reads 1 for exactly 65 cycles: 64 rounds and then one cycle that adds the working variables into the state. After that, the new digest is readable.
- R6: While busy, writes to block registers and the start commands 0xA and 0xE are ignored.
- R7: Writing 0x10 and then, as the very next control write, 0x0 clears all state words to 0 and clears busy. This is honoured even in the middle of a compression.
- R8: A control write of 0x0 that does not directly follow 0x10 has no effect. The state words (indices 24..31, word 0 at index 24 being the first digest word) are read-only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W (6) | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |

## Verification
The engine is tried with three standard messages:
- The empty message and the three-byte message each fit in a single block. They tell apart errors in the round function, the constants and the message schedule, because each gives a well-known digest.
- The 56-byte message needs a second, length-only block issued with the continuation command. A correct result shows that chaining starts from the stored state and not from the initial hash.
- A first-block command run after a digest is already held shows that the initial hash is reloaded.

Further patterns cover writes and starts during a run, the arm-then-clear sequence issued mid-run, and a lone clear write. These show whether the ignore rules and the initialise sequence are decoded correctly.

// File: rtl/sha_eng_pkg.sv
package sha_eng_pkg;
  localparam int WORD_W     = 32;
  localparam int BLK_WORDS  = 16;
  localparam int ST_WORDS   = 8;
  localparam int NUM_ROUNDS = 64;
  localparam int RND_W      = $clog2(NUM_ROUNDS);
  localparam int BLK_IDX_W  = $clog2(BLK_WORDS);
  localparam int ST_IDX_W   = $clog2(ST_WORDS);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ST_WORDS-1:0][WORD_W-1:0] hstate_t;   // index 0 = a
  typedef logic [BLK_WORDS-1:0][WORD_W-1:0] hblock_t;  // index 0 = W[0]

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FIN} phase_t;

  localparam word_t CMD_ARM   = 32'h0000_0010;
  localparam word_t CMD_CLEAR = 32'h0000_0000;
  localparam word_t CMD_FIRST = 32'h0000_000A;
  localparam word_t CMD_NEXT  = 32'h0000_000E;

  localparam hstate_t IV_VEC = {
    32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
    32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667};

  localparam word_t K_TAB [NUM_ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  function automatic word_t rotr(word_t x, int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_sig0(word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_sig1(word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_sig0(word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_sig1(word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/sha_blk_regs.sv
module sha_blk_regs
  import sha_eng_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [BLK_IDX_W-1:0] idx_i,
  input  word_t                data_i,
  input  logic                 busy_i,
  output hblock_t              blk_o
);
  hblock_t blk_q;
  logic    wr_ok;

  assign wr_ok = wr_i && !busy_i;
  assign blk_o = blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
    end else if (wr_ok) begin
      for (int i = 0; i < BLK_WORDS; i++) begin
        if (idx_i == BLK_IDX_W'(i)) blk_q[i] <= data_i;
      end
    end
  end

  // R6: block words are frozen while a compression runs
  p_block_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(blk_q));
endmodule

// File: rtl/sha_msg_sched.sv
module sha_msg_sched
  import sha_eng_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_i,
  input  logic    step_i,
  input  hblock_t blk_i,
  output word_t   w_o
);
  hblock_t win_q, win_d;
  logic    win_en;

  assign win_en = load_i || step_i;
  assign w_o    = win_q[0];

  always_comb begin
    win_d = win_q;
    if (load_i) begin
      win_d = blk_i;
    end else if (step_i) begin
      for (int i = 0; i < BLK_WORDS-1; i++) win_d[i] = win_q[i+1];
      win_d[BLK_WORDS-1] = sml_sig1(win_q[14]) + win_q[9] + sml_sig0(win_q[1]) + win_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_d;
  end
endmodule

// File: rtl/sha_round_dp.sv
module sha_round_dp
  import sha_eng_pkg::*;
(
  input  hstate_t v_i,
  input  word_t   k_i,
  input  word_t   w_i,
  output hstate_t v_o
);
  word_t t1, t2, ch_v, maj_v;

  always_comb begin
    ch_v  = (v_i[4] & v_i[5]) ^ (~v_i[4] & v_i[6]);
    maj_v = (v_i[0] & v_i[1]) ^ (v_i[0] & v_i[2]) ^ (v_i[1] & v_i[2]);
    t1    = v_i[7] + big_sig1(v_i[4]) + ch_v + k_i + w_i;
    t2    = big_sig0(v_i[0]) + maj_v;
    v_o[0] = t1 + t2;
    v_o[1] = v_i[0];
    v_o[2] = v_i[1];
    v_o[3] = v_i[2];
    v_o[4] = v_i[3] + t1;
    v_o[5] = v_i[4];
    v_o[6] = v_i[5];
    v_o[7] = v_i[6];
  end
endmodule

// File: rtl/sha256_cmd_engine.sv
module sha256_cmd_engine
  import sha_eng_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam logic [ADDR_W-1:0] CTRL_IDX = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] BLK_LO   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] BLK_HI   = ADDR_W'(4 + BLK_WORDS - 1);
  localparam logic [ADDR_W-1:0] ST_LO    = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] ST_HI    = ADDR_W'(24 + ST_WORDS - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  phase_t           phase_q, phase_d;
  logic [RND_W-1:0] rnd_q, rnd_d;
  logic             arm_q, arm_d, arm_en;
  hstate_t          st_q, st_d, wv_q, wv_d, rnd_out, sum_w;
  logic             st_en, wv_en, rnd_en;
  hblock_t          blk;
  word_t            w_cur;

  logic busy, ctrl_wr, blk_sel, st_sel, init_fire, go_first, go_next;

  assign busy      = (phase_q != PH_IDLE);
  assign ctrl_wr   = bus_wr && (bus_addr == CTRL_IDX);
  assign blk_sel   = (bus_addr >= BLK_LO) && (bus_addr <= BLK_HI);
  assign st_sel    = (bus_addr >= ST_LO) && (bus_addr <= ST_HI);
  assign init_fire = ctrl_wr && (bus_wdata == CMD_CLEAR) && arm_q;
  assign go_first  = ctrl_wr && (bus_wdata == CMD_FIRST) && !busy;
  assign go_next   = ctrl_wr && (bus_wdata == CMD_NEXT) && !busy;
  assign arm_en    = ctrl_wr;
  assign arm_d     = (bus_wdata == CMD_ARM);

  sha_blk_regs u_blk (
    .clk(clk), .rst_n(rst_sync_n), .wr_i(bus_wr && blk_sel),
    .idx_i(BLK_IDX_W'(bus_addr - BLK_LO)), .data_i(bus_wdata),
    .busy_i(busy), .blk_o(blk));

  sha_msg_sched u_sched (
    .clk(clk), .rst_n(rst_sync_n), .load_i(go_first || go_next),
    .step_i(phase_q == PH_RUN), .blk_i(blk), .w_o(w_cur));

  sha_round_dp u_round (
    .v_i(wv_q), .k_i(K_TAB[rnd_q]), .w_i(w_cur), .v_o(rnd_out));

  for (genvar g = 0; g < ST_WORDS; g++) begin : g_fold
    assign sum_w[g] = st_q[g] + wv_q[g];
  end

  always_comb begin
    phase_d = phase_q;
    rnd_d   = rnd_q;
    st_d    = st_q;
    wv_d    = wv_q;
    st_en   = 1'b0;
    wv_en   = 1'b0;
    rnd_en  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (go_first) begin
          st_d = IV_VEC;  st_en = 1'b1;
          wv_d = IV_VEC;  wv_en = 1'b1;
          rnd_d = '0;     rnd_en = 1'b1;
          phase_d = PH_RUN;
        end else if (go_next) begin
          wv_d = st_q;    wv_en = 1'b1;
          rnd_d = '0;     rnd_en = 1'b1;
          phase_d = PH_RUN;
        end
      end
      PH_RUN: begin
        wv_d = rnd_out;    wv_en = 1'b1;
        rnd_d = rnd_q + 1'b1; rnd_en = 1'b1;
        if (rnd_q == RND_W'(NUM_ROUNDS - 1)) phase_d = PH_FIN;
      end
      default: begin
        st_d = sum_w;   st_en = 1'b1;
        phase_d = PH_IDLE;
      end
    endcase
    if (init_fire) begin
      st_d    = '0;
      st_en   = 1'b1;
      phase_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= PH_IDLE;
      rnd_q   <= '0;
      arm_q   <= 1'b0;
      st_q    <= '0;
      wv_q    <= '0;
    end else begin
      phase_q <= phase_d;
      if (rnd_en) rnd_q <= rnd_d;
      if (arm_en) arm_q <= arm_d;
      if (st_en)  st_q  <= st_d;
      if (wv_en)  wv_q  <= wv_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_IDX) bus_rdata = {31'b0, busy};
    else if (blk_sel)         bus_rdata = blk[BLK_IDX_W'(bus_addr - BLK_LO)];
    else if (st_sel)          bus_rdata = st_q[ST_IDX_W'(bus_addr - ST_LO)];
  end

  // checker: length of each busy period
  logic [RND_W:0] chk_cnt;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) chk_cnt <= '0;
    else if (busy)   chk_cnt <= chk_cnt + 1'b1;
    else             chk_cnt <= '0;
  end

  // R5: never longer than 65 busy cycles
  p_busy_max_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> (chk_cnt <= (RND_W+1)'(NUM_ROUNDS)));
  // R5: a normal end comes only after the full 65 cycles
  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($fell(busy) && !$past(init_fire)) |-> ($past(chk_cnt) == (RND_W+1)'(NUM_ROUNDS)));
  // R3: first-block start seeds the initial hash
  p_start_iv_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    go_first |=> (st_q == IV_VEC));
  // R7: clear sequence zeroes the state and ends busy
  p_init_zero_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    init_fire |=> ((st_q == '0) && !busy));
  // R8: state changes only on a start, a finalise or a clear
  p_state_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((phase_q != PH_FIN) && !go_first && !init_fire) |=> $stable(st_q));
endmodule

// File: tb/sha256_cmd_engine_bench.sv
module sha256_cmd_engine_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  sha256_cmd_engine u_sha256_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       exp_q[$];
  int          total = 0;
  int          bad   = 0;
  bit          done  = 0;
  logic [31:0] blkw [16];

  localparam logic [255:0] DG_ABC   = 256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad;
  localparam logic [255:0] DG_EMPTY = 256'he3b0c442_98fc1c14_9afbf4c8_996fb924_27ae41e4_649b934c_a495991b_7852b855;
  localparam logic [255:0] DG_TWO   = 256'h248d6a61_d20638b8_e5c02693_0c3e6039_a33ce459_64ff2167_f6ecedd4_19db06c1;

  task automatic note(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each expected item with the read data
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      note(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
    end
  end

  task automatic chk(input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_wr   = 1'b0;
    bus_addr = a;
    it.exp = e;
    it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic load_blk();
    for (int i = 0; i < 16; i++) wr(6'(4 + i), blkw[i]);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    bus_addr = 6'd0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (bus_rdata[0]) n++;
      else break;
    end
  endtask

  task automatic chk_digest(input logic [255:0] d, input string tag);
    for (int i = 0; i < 8; i++) chk(6'(24 + i), d[255 - 32*i -: 32], tag);
  endtask

  task automatic set_abc();
    for (int i = 0; i < 16; i++) blkw[i] = '0;
    blkw[0]  = 32'h61626380;
    blkw[15] = 32'h00000018;
  endtask

  initial begin
    int n;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state
    chk(6'd0,  32'h0, "R1 ctrl");
    chk(6'd24, 32'h0, "R1 state0");
    chk(6'd31, 32'h0, "R1 state7");
    chk(6'd4,  32'h0, "R1 blk0");
    chk(6'd19, 32'h0, "R1 blk15");

    // R2 + R3 + R5: single block "abc"
    set_abc();
    load_blk();
    chk(6'd4,  32'h61626380, "R2 blk0 readback");
    chk(6'd19, 32'h00000018, "R2 blk15 readback");
    wr(6'd0, 32'hA);
    wait_idle(n);
    note(n == 65, "R5 busy cycles", 32'(n), 32'd65);
    chk(6'd0, 32'h0, "R5 ctrl idle");
    chk_digest(DG_ABC, "R3 abc digest");
    chk(6'd4, 32'h61626380, "R2 blk kept after run");

    // R8: lone clear write and write to state area
    wr(6'd0, 32'h0);
    chk(6'd24, DG_ABC[255 -: 32], "R8 lone clear ignored");
    wr(6'd24, 32'h0);
    chk(6'd24, DG_ABC[255 -: 32], "R8 state read-only");

    // R4: two-block message, continuation chains
    blkw = '{32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
             32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
             32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
             32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
    load_blk();
    wr(6'd0, 32'hA);
    wait_idle(n);
    for (int i = 0; i < 16; i++) blkw[i] = '0;
    blkw[15] = 32'h000001c0;
    load_blk();
    wr(6'd0, 32'hE);
    wait_idle(n);
    note(n == 65, "R5 busy cycles next", 32'(n), 32'd65);
    chk_digest(DG_TWO, "R4 chained digest");

    // R3: first-block command reseeds over a held digest
    for (int i = 0; i < 16; i++) blkw[i] = '0;
    blkw[0] = 32'h80000000;
    load_blk();
    wr(6'd0, 32'hA);
    wait_idle(n);
    chk_digest(DG_EMPTY, "R3 empty digest reseed");

    // R6: writes during a run are ignored
    set_abc();
    load_blk();
    wr(6'd0, 32'hA);
    wr(6'd4, 32'hDEADBEEF);
    wr(6'd0, 32'hE);
    wait_idle(n);
    chk_digest(DG_ABC, "R6 digest unaffected");
    chk(6'd4, 32'h61626380, "R6 blk write ignored");
    chk(6'd0, 32'h0, "R6 no extra run");

    // R7: clear sequence in mid-run
    wr(6'd0, 32'hA);
    repeat (5) @(posedge clk);
    wr(6'd0, 32'h10);
    wr(6'd0, 32'h0);
    chk(6'd0,  32'h0, "R7 busy cleared");
    chk(6'd24, 32'h0, "R7 state0 zero");
    chk(6'd31, 32'h0, "R7 state7 zero");

    // R7: clear sequence when idle after a digest
    wr(6'd0, 32'hA);
    wait_idle(n);
    chk(6'd24, DG_ABC[255 -: 32], "R7 pre-clear digest");
    wr(6'd0, 32'h10);
    wr(6'd0, 32'h0);
    chk(6'd27, 32'h0, "R7 idle clear");

    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R5 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule